// File: doc/BRIEF.md
# 32-bit Integer ALU with Multiply

This block is a purely combinational arithmetic logic unit for a small integer core. It takes two 32-bit operands, `opA` and `opB`, and a 4-bit operation code. It returns a single 32-bit result in the same cycle. The operations are bitwise logic, wrap-around add and subtract, three flavours of 32x32 multiply, three shifts, and signed and unsigned less-than tests.

Internally a control decoder turns the operation code into a small struct of selection strobes. A datapath module computes every candidate result and picks one according to those strobes. The top module only wires the two together. There are no flags and no internal state. The multiply is single-cycle, and the result settles within the same evaluation as the inputs.

Top module: `mul_alu32`

## Requirements
- R1: Code 4'b0000 gives opA & opB, code 4'b0001 gives opA | opB, and code 4'b0010 gives opA ^ opB.
- R2: Code 4'b0011 gives opA + opB modulo 2^32, and the carry out is dropped.
- R3: Code 4'b0100 gives opA - opB modulo 2^32.
- R4: Code 4'b0101 gives bits 31:0 of the product opA*opB.
- R5: Code 4'b0110 gives bits 63:32 of the product, with both operands taken as signed two's complement.
- R6: Code 4'b0111 gives bits 63:32 of the product, with both operands taken as unsigned.
- R7: Codes 4'b1000, 4'b1001 and 4'b1010 shift opA left logically, right logically and right arithmetically, in that order. The shift amount is opB[4:0], and opB[31:5] has no effect on the result.
- R8: Code 4'b1100 compares opA < opB as signed values. The outcome (1 or 0) goes in bit 0 of the result, and bits 31:1 are zero.
- R9: Codes 4'b1101, 4'b1110 and 4'b1111 each compare opA < opB as unsigned values. The outcome goes in bit 0, and bits 31:1 are zero.
- R10: The unassigned code 4'b1011 gives a result of zero for any operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand; this is the value that is shifted |
| opB | input | 32 | Second operand; its low 5 bits are the shift amount |
| opCode | input | 4 | Selects the operation |
| result | output | 32 | Outcome of the selected operation |

## Verification
The multiply codes are driven with all-ones operands and with the most negative value. These inputs make the signed and unsigned high halves come apart: -1 times -1 has a high half of zero, while the unsigned product has a high half of 0xFFFFFFFE. The compare codes are driven with -1 against 1, so signed and unsigned ordering disagree, and with equal operands, which must give zero. Shifts are tried with junk in opB[31:5] and with a zero amount, and the arithmetic right shift gets a negative operand so that sign fill is visible. A sweep of pseudo-random operands then covers all sixteen codes, including the unassigned one, against an independent model in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND  = 4'b0000,
    OP_OR   = 4'b0001,
    OP_XOR  = 4'b0010,
    OP_ADD  = 4'b0011,
    OP_SUB  = 4'b0100,
    OP_MULL = 4'b0101,
    OP_MULS = 4'b0110,
    OP_MULU = 4'b0111,
    OP_SHL  = 4'b1000,
    OP_SHR  = 4'b1001,
    OP_SRA  = 4'b1010,
    OP_GAP  = 4'b1011,
    OP_LTS  = 4'b1100,
    OP_LTU0 = 4'b1101,
    OP_LTU1 = 4'b1110,
    OP_LTU2 = 4'b1111
  } aluOp_e;

  typedef enum logic [2:0] {
    UNIT_NONE,
    UNIT_LOGIC,
    UNIT_ARITH,
    UNIT_MUL,
    UNIT_SHIFT,
    UNIT_CMP
  } unitSel_e;

  typedef enum logic [1:0] {
    LOGIC_AND,
    LOGIC_OR,
    LOGIC_XOR
  } logicKind_e;

  typedef struct packed {
    unitSel_e   unitSel;
    logicKind_e logicKind;
    logic       subtract;
    logic       mulHigh;
    logic       mulSigned;
    logic       shiftRight;
    logic       shiftArith;
    logic       cmpSigned;
  } aluStrobe_t;

endpackage

// File: rtl/alu_control.sv
module alu_control
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluStrobe_t      strb
);

  always_comb begin
    strb = '{unitSel: UNIT_NONE, logicKind: LOGIC_AND, default: 1'b0};
    unique case (opCode)
      OP_AND:  begin strb.unitSel = UNIT_LOGIC; strb.logicKind = LOGIC_AND; end
      OP_OR:   begin strb.unitSel = UNIT_LOGIC; strb.logicKind = LOGIC_OR;  end
      OP_XOR:  begin strb.unitSel = UNIT_LOGIC; strb.logicKind = LOGIC_XOR; end
      OP_ADD:  strb.unitSel = UNIT_ARITH;
      OP_SUB:  begin strb.unitSel = UNIT_ARITH; strb.subtract = 1'b1; end
      OP_MULL: strb.unitSel = UNIT_MUL;
      OP_MULS: begin strb.unitSel = UNIT_MUL; strb.mulHigh = 1'b1; strb.mulSigned = 1'b1; end
      OP_MULU: begin strb.unitSel = UNIT_MUL; strb.mulHigh = 1'b1; end
      OP_SHL:  strb.unitSel = UNIT_SHIFT;
      OP_SHR:  begin strb.unitSel = UNIT_SHIFT; strb.shiftRight = 1'b1; end
      OP_SRA:  begin strb.unitSel = UNIT_SHIFT; strb.shiftRight = 1'b1; strb.shiftArith = 1'b1; end
      OP_LTS:  begin strb.unitSel = UNIT_CMP; strb.cmpSigned = 1'b1; end
      OP_LTU0, OP_LTU1, OP_LTU2: strb.unitSel = UNIT_CMP;
      default: strb.unitSel = UNIT_NONE;
    endcase
  end

  // Strobe sanity: modifiers only appear with their own unit.
  always_comb begin
    p_mod_unit_r7: assert (!(strb.shiftArith && !strb.shiftRight))
      else $error("p_mod_unit_r7: arithmetic shift without right shift");
    p_mulsign_r5: assert (!(strb.mulSigned && !strb.mulHigh))
      else $error("p_mulsign_r5: signed multiply flag without high half");
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluStrobe_t        strb,
  output logic [DATA_W-1:0] result
);

  localparam int unsigned SH_W   = $clog2(DATA_W);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] logicRes, arithRes, mulRes, shiftRes, cmpRes;
  logic [PROD_W-1:0] extA, extB, prod;
  logic [SH_W-1:0]   shAmt;
  logic              lessBit;

  always_comb begin
    unique case (strb.logicKind)
      LOGIC_OR:  logicRes = opA | opB;
      LOGIC_XOR: logicRes = opA ^ opB;
      default:   logicRes = opA & opB;
    endcase
  end

  assign arithRes = strb.subtract ? (opA - opB) : (opA + opB);

  // Sign-extend to double width so one unsigned product serves both signs.
  assign extA   = {{DATA_W{strb.mulSigned & opA[DATA_W-1]}}, opA};
  assign extB   = {{DATA_W{strb.mulSigned & opB[DATA_W-1]}}, opB};
  assign prod   = extA * extB;
  assign mulRes = strb.mulHigh ? prod[PROD_W-1:DATA_W] : prod[DATA_W-1:0];

  assign shAmt = opB[SH_W-1:0];
  always_comb begin
    if (!strb.shiftRight)     shiftRes = opA << shAmt;
    else if (strb.shiftArith) shiftRes = DATA_W'($signed(opA) >>> shAmt);
    else                      shiftRes = opA >> shAmt;
  end

  assign lessBit = strb.cmpSigned ? ($signed(opA) < $signed(opB)) : (opA < opB);
  assign cmpRes  = {{(DATA_W-1){1'b0}}, lessBit};

  always_comb begin
    unique case (strb.unitSel)
      UNIT_LOGIC: result = logicRes;
      UNIT_ARITH: result = arithRes;
      UNIT_MUL:   result = mulRes;
      UNIT_SHIFT: result = shiftRes;
      UNIT_CMP:   result = cmpRes;
      default:    result = '0;
    endcase
  end

  always_comb begin
    if (strb.unitSel == UNIT_CMP) begin
      p_cmp_upper_r8: assert (result[DATA_W-1:1] == '0)
        else $error("p_cmp_upper_r8: compare result has upper bits set");
      if (opA == opB) begin
        p_cmp_equal_r9: assert (result == '0)
          else $error("p_cmp_equal_r9: equal operands compared as less");
      end
    end
    if (strb.unitSel == UNIT_SHIFT && shAmt == '0) begin
      p_shift_zero_r7: assert (result == opA)
        else $error("p_shift_zero_r7: zero shift changed operand");
    end
  end

endmodule

// File: rtl/mul_alu32.sv
module mul_alu32
  import alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [OP_W-1:0]   opCode,
  output logic [DATA_W-1:0] result
);

  aluStrobe_t strb;

  alu_control ctrl_i (
    .opCode (opCode),
    .strb   (strb)
  );

  alu_datapath #(.DATA_W(DATA_W)) dp_i (
    .opA    (opA),
    .opB    (opB),
    .strb   (strb),
    .result (result)
  );

  always_comb begin
    if (opCode == OP_GAP) begin
      p_gap_zero_r10: assert (result == '0)
        else $error("p_gap_zero_r10: unassigned code gave nonzero");
    end
    if (opCode == OP_ADD) begin
      p_add_inv_r2: assert (result - opB == opA)
        else $error("p_add_inv_r2: sum does not invert");
    end
    if (opCode == OP_SUB) begin
      p_sub_inv_r3: assert (result + opB == opA)
        else $error("p_sub_inv_r3: difference does not invert");
    end
  end

endmodule

// File: tb/mul_alu32_tb_top.sv
module mul_alu32_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  opCode = '0;
  logic [31:0] result;

  int total = 0;
  int bad   = 0;
  bit driverDone = 1'b0;

  typedef struct {
    logic [31:0] expVal;
    string       tag;
  } item_t;

  item_t sbQ[$];

  always #4 clk = ~clk;   // 125 MHz

  mul_alu32 dut_i (
    .opA    (opA),
    .opB    (opB),
    .opCode (opCode),
    .result (result)
  );

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] pu;
    longint      ps;
    logic [4:0]  s;
    s  = b[4:0];
    pu = {32'd0, a} * {32'd0, b};
    ps = longint'($signed(a)) * longint'($signed(b));
    case (op)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0010: return a ^ b;
      4'b0011: return a + b;
      4'b0100: return a - b;
      4'b0101: return pu[31:0];
      4'b0110: return ps[63:32];
      4'b0111: return pu[63:32];
      4'b1000: return a << s;
      4'b1001: return a >> s;
      4'b1010: return ({{32{a[31]}}, a} >> s);
      4'b1100: return {31'd0, ($signed(a) < $signed(b))};
      4'b1101, 4'b1110, 4'b1111: return {31'd0, (a < b)};
      default: return 32'd0;
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] expVal, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    opCode = op; opA = a; opB = b;
    it.expVal = expVal;
    it.tag    = tag;
    sbQ.push_back(it);
  endtask

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'b0000, 4'b0001, 4'b0010: return "R1";
      4'b0011: return "R2";
      4'b0100: return "R3";
      4'b0101: return "R4";
      4'b0110: return "R5";
      4'b0111: return "R6";
      4'b1000, 4'b1001, 4'b1010: return "R7";
      4'b1100: return "R8";
      4'b1011: return "R10";
      default: return "R9";
    endcase
  endfunction

  // Monitor: sample mid-cycle, away from the driving edge.
  always @(negedge clk) begin
    if (!rst && sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      total++;
      if (result !== it.expVal) begin
        bad++;
        $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", it.tag, opCode, opA, opB, result, it.expVal);
      end
    end
  end

  initial begin : driver
    logic [31:0] lfsr;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // Idle inputs: AND of zeros gives zero (R1).
    drive(4'b0000, 32'h0, 32'h0, 32'h0, "R1");
    drive(4'b0000, 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200, "R1");
    drive(4'b0001, 32'hF000_000F, 32'h0F00_00F0, 32'hFF00_00FF, "R1");
    drive(4'b0010, 32'hAAAA_5555, 32'hFFFF_0000, 32'h5555_5555, "R1");
    drive(4'b0011, 32'hFFFF_FFFF, 32'h1, 32'h0, "R2");
    drive(4'b0100, 32'h0, 32'h1, 32'hFFFF_FFFF, "R3");
    drive(4'b0101, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, "R4");
    drive(4'b0101, 32'h0001_0000, 32'h0001_0003, 32'h0003_0000, "R4");
    drive(4'b0110, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, "R5");
    drive(4'b0110, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, "R5");
    drive(4'b0110, 32'hFFFF_FFFF, 32'h2, 32'hFFFF_FFFF, "R5");
    drive(4'b0111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, "R6");
    drive(4'b0111, 32'hFFFF_FFFF, 32'h2, 32'h1, "R6");
    drive(4'b1000, 32'h0000_0011, 32'hFFFF_FFE3, 32'h0000_0088, "R7");
    drive(4'b1001, 32'h8000_0000, 32'h0000_0023, 32'h1000_0000, "R7");
    drive(4'b1010, 32'h8000_0000, 32'h0000_001F, 32'hFFFF_FFFF, "R7");
    drive(4'b1010, 32'h8000_0010, 32'hFFFF_FFE0, 32'h8000_0010, "R7");
    drive(4'b1100, 32'hFFFF_FFFF, 32'h1, 32'h1, "R8");
    drive(4'b1100, 32'h5, 32'h5, 32'h0, "R8");
    drive(4'b1101, 32'hFFFF_FFFF, 32'h1, 32'h0, "R9");
    drive(4'b1110, 32'h1, 32'hFFFF_FFFF, 32'h1, "R9");
    drive(4'b1111, 32'h7, 32'h8, 32'h1, "R9");
    drive(4'b1011, 32'hDEAD_BEEF, 32'h1234_5678, 32'h0, "R10");
    lfsr = 32'hACE1_1357;
    for (int i = 0; i < 320; i++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = lfsr ^ 32'h9E37_79B9;
      drive(4'(i % 16), a, b, model(4'(i % 16), a, b), tagOf(4'(i % 16)));
    end
    @(posedge clk);
    @(posedge clk);
    driverDone = 1'b1;
  end

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!driverDone && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!driverDone) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule